// File: doc/BRIEF.md
# Limit-Check Interrupt Controller

This block sits beside a monitoring converter and turns each fresh measurement into an alarm decision. Whenever a measurement-valid strobe arrives with a channel index and an 8-bit value, the block compares the value against the programmed limits for that channel. Voltage channels use a high and a low limit. Fan channels use a single period-count ceiling. The temperature channel uses a high limit and a hysteresis limit. A failing comparison sets a sticky bit in one of two 8-bit status bytes. A chassis-intrusion input sets a bit of its own.

Each status bit has a mask bit. The status bits that are not masked are combined into one active-low interrupt line. Two configuration inputs gate that line: an enable input and a clear input. While the clear input is high, measurements are ignored and the line is released, and the stored status is left as it is. Reading a status byte returns its contents and clears it.

The temperature alarm has three behaviours, chosen by a 2-bit mode register:
- **Repeating:** the alarm is raised again on every conversion while the temperature stays hot.
- **One-shot:** the alarm is raised once per excursion.
- **Comparator:** the alarm bit follows the over-limit result of each conversion.

Top module: `limit_irq_ctrl`

## Requirements
- R1: A measurement on voltage channel v (index 0 to 5) sets status bit v when its unsigned value is strictly above that channel's high limit or strictly below its low limit. Status bit v is visible one clock after the strobe. A value equal to either limit sets nothing.
- R2: A measurement on fan channel f (index 7 or 8) sets status bit 7+f-7, that is bit 7 or bit 8, when its unsigned count is strictly greater than that fan's count limit. A count equal to the limit sets nothing.
- R3: Status bits are sticky. A read strobe for byte 0 (bits 7..0) or byte 1 (bits 15..8) leaves the byte unchanged on its output during the strobe cycle and zeroes that byte on the next clock. The other byte is not touched.
- R4: A status bit whose mask bit is 1 cannot pull the interrupt line low.
- R5: The interrupt output is low only when the enable input is 1, the clear input is 0, and at least one unmasked status bit is set.
- R6: While the clear input is 1, the interrupt output is high, measurements have no effect, and the status bytes keep their contents.
- R7: While the chassis-intrusion input is high, status bit 9 (byte 1 bit 1) is set on every clock, even in a cycle where byte 1 is read.
- R8: The temperature mode register resets to 01 (one-shot) and loads a new 2-bit value on a mode write strobe.
- R9: In mode 00, and likewise in mode 11, a temperature conversion on channel 6 sets status bit 6 when the value is above the high limit. After that, every later conversion sets bit 6 again until a value strictly below the hysteresis limit has been converted.
- R10: In mode 01, bit 6 is set only by a conversion above the high limit that follows a conversion below the hysteresis limit, or that follows reset. Further hot conversions raise nothing until the temperature has gone below the hysteresis limit again.
- R11: In mode 10, each conversion on channel 6 writes bit 6 with the result of value > high limit, so a cool conversion clears the bit.
- R12: Temperature values and both temperature limits are compared as 8-bit two's complement numbers.
- R13: A strobe with a channel index of 9 or above changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | A new measurement is present this cycle |
| meas_chan | input | 4 | Channel index of the measurement |
| meas_value | input | 8 | Measured value or period count |
| volt_hi | input | 48 | High limits, 8 bits per voltage channel, channel 0 in the low byte |
| volt_lo | input | 48 | Low limits, 8 bits per voltage channel |
| fan_lim | input | 16 | Count ceilings, 8 bits per fan |
| temp_hi | input | 8 | Temperature high limit (two's complement) |
| temp_hyst | input | 8 | Temperature hysteresis limit (two's complement) |
| mode_we | input | 1 | Load the temperature mode register |
| mode_wdata | input | 2 | New temperature mode |
| irq_mask | input | 16 | Per-status-bit mask, 1 = masked |
| chassis_in | input | 1 | Chassis-intrusion level |
| int_enable | input | 1 | Interrupt output enable |
| int_clear | input | 1 | Releases the interrupt and pauses updates |
| rd_stat0 | input | 1 | Read strobe for status byte 0 |
| rd_stat1 | input | 1 | Read strobe for status byte 1 |
| stat0 | output | 8 | Status byte 0 |
| stat1 | output | 8 | Status byte 1 |
| int_n | output | 1 | Active-low combined interrupt |

## Verification
The checker assumes the following about the inputs:
- Limits and masks are held steady around a measurement strobe.
- Every channel index in a strobe is a legal 4-bit value.
- A read strobe lasts one cycle.

The read-clear and pause properties exclude cycles in which a strobe or the chassis input could legitimately set a bit, so they assume no other source writes status in those cycles. The stimulus follows these rules:
- It changes limits only at reset.
- It drives strobes and reads for one cycle each, on the falling edge.
- It never reads a byte in the same cycle as a measurement, so no check depends on set-versus-clear priority. The chassis case is the deliberate exception.

// File: rtl/lci_pkg.sv
package lci_pkg;

    localparam int STAT_W = 16;

    typedef enum logic [1:0] {
        TM_REPEAT     = 2'b00,
        TM_ONESHOT    = 2'b01,
        TM_COMPARE    = 2'b10,
        TM_REPEAT_ALT = 2'b11
    } temp_mode_e;

endpackage

// File: rtl/lci_range_check.sv
module lci_range_check #(
    parameter int N_VOLT = 6,
    parameter int N_FAN  = 2,
    parameter int DW     = 8,
    parameter int CHW    = 4
) (
    input  logic                  valid,
    input  logic [CHW-1:0]        chan,
    input  logic [DW-1:0]         value,
    input  logic [N_VOLT*DW-1:0]  volt_hi,
    input  logic [N_VOLT*DW-1:0]  volt_lo,
    input  logic [N_FAN*DW-1:0]   fan_lim,
    output logic [N_VOLT-1:0]     volt_err,
    output logic [N_FAN-1:0]      fan_err,
    output logic                  temp_sel
);

    for (genvar v = 0; v < N_VOLT; v++) begin : g_volt
        localparam logic [CHW-1:0] IDX = CHW'(v);
        assign volt_err[v] = valid && (chan == IDX) &&
                             ((value > volt_hi[v*DW +: DW]) ||
                              (value < volt_lo[v*DW +: DW]));
    end

    for (genvar f = 0; f < N_FAN; f++) begin : g_fan
        localparam logic [CHW-1:0] IDX = CHW'(N_VOLT + 1 + f);
        assign fan_err[f] = valid && (chan == IDX) &&
                            (value > fan_lim[f*DW +: DW]);
    end

    localparam logic [CHW-1:0] TIDX = CHW'(N_VOLT);
    assign temp_sel = valid && (chan == TIDX);

endmodule

// File: rtl/lci_temp_eval.sv
module lci_temp_eval #(
    parameter int DW = 8
) (
    input  logic          conv,
    input  logic [DW-1:0] value,
    input  logic [DW-1:0] hi_lim,
    input  logic [DW-1:0] hyst_lim,
    input  logic [1:0]    mode,
    input  logic          hot_q,
    input  logic          cur_bit,
    output logic          hot_d,
    output logic          bit_d
);
    import lci_pkg::*;

    logic over;
    logic below;
    logic hot_next;

    always_comb begin
        over     = $signed(value) > $signed(hi_lim);
        below    = $signed(value) < $signed(hyst_lim);
        hot_next = over | (hot_q & ~below);
        hot_d    = hot_q;
        bit_d    = cur_bit;
        if (conv) begin
            hot_d = hot_next;
            case (temp_mode_e'(mode))
                TM_ONESHOT: bit_d = cur_bit | (over & ~hot_q);
                TM_COMPARE: bit_d = over;
                default:    bit_d = cur_bit | hot_next;
            endcase
        end
    end

endmodule

// File: rtl/limit_irq_ctrl.sv
module limit_irq_ctrl #(
    parameter  int N_VOLT = 6,
    parameter  int N_FAN  = 2,
    parameter  int DW     = 8,
    localparam int NSRC   = N_VOLT + N_FAN + 2,
    localparam int CHW    = $clog2(NSRC + 1),
    localparam int SW     = lci_pkg::STAT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 meas_valid,
    input  logic [CHW-1:0]       meas_chan,
    input  logic [DW-1:0]        meas_value,
    input  logic [N_VOLT*DW-1:0] volt_hi,
    input  logic [N_VOLT*DW-1:0] volt_lo,
    input  logic [N_FAN*DW-1:0]  fan_lim,
    input  logic [DW-1:0]        temp_hi,
    input  logic [DW-1:0]        temp_hyst,
    input  logic                 mode_we,
    input  logic [1:0]           mode_wdata,
    input  logic [SW-1:0]        irq_mask,
    input  logic                 chassis_in,
    input  logic                 int_enable,
    input  logic                 int_clear,
    input  logic                 rd_stat0,
    input  logic                 rd_stat1,
    output logic [7:0]           stat0,
    output logic [7:0]           stat1,
    output logic                 int_n
);
    import lci_pkg::*;

    localparam int TBIT = N_VOLT;
    localparam int FBIT = N_VOLT + 1;
    localparam int CBIT = N_VOLT + N_FAN + 1;

    typedef struct packed {
        logic [SW-1:0] stat;
        logic          hot;
        logic [1:0]    mode;
    } state_t;

    state_t q, d;

    logic              upd;
    logic [N_VOLT-1:0] volt_err;
    logic [N_FAN-1:0]  fan_err;
    logic              temp_sel;
    logic [SW-1:0]     base;
    logic [SW-1:0]     set_vec;
    logic              hot_d;
    logic              tbit_d;

    assign upd = meas_valid & ~int_clear;

    lci_range_check #(
        .N_VOLT (N_VOLT),
        .N_FAN  (N_FAN),
        .DW     (DW),
        .CHW    (CHW)
    ) i_range (
        .valid    (upd),
        .chan     (meas_chan),
        .value    (meas_value),
        .volt_hi  (volt_hi),
        .volt_lo  (volt_lo),
        .fan_lim  (fan_lim),
        .volt_err (volt_err),
        .fan_err  (fan_err),
        .temp_sel (temp_sel)
    );

    // byte-wise read clear applied before new sets
    assign base = {rd_stat1 ? 8'h00 : q.stat[15:8],
                   rd_stat0 ? 8'h00 : q.stat[7:0]};

    always_comb begin
        set_vec = '0;
        set_vec[N_VOLT-1:0]      = volt_err;
        set_vec[FBIT +: N_FAN]   = fan_err;
        set_vec[CBIT]            = chassis_in;
    end

    lci_temp_eval #(
        .DW (DW)
    ) i_temp (
        .conv     (temp_sel),
        .value    (meas_value),
        .hi_lim   (temp_hi),
        .hyst_lim (temp_hyst),
        .mode     (q.mode),
        .hot_q    (q.hot),
        .cur_bit  (base[TBIT]),
        .hot_d    (hot_d),
        .bit_d    (tbit_d)
    );

    always_comb begin
        d = q;
        if (mode_we) begin
            d.mode = mode_wdata;
        end
        d.stat       = base | set_vec;
        d.stat[TBIT] = tbit_d;
        d.hot        = hot_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.stat <= '0;
            q.hot  <= 1'b0;
            q.mode <= TM_ONESHOT;
        end else begin
            q <= d;
        end
    end

    assign stat0 = q.stat[7:0];
    assign stat1 = q.stat[15:8];
    assign int_n = ~(int_enable & ~int_clear & (|(q.stat & ~irq_mask)));

endmodule

// File: rtl/lci_checker.sv
module lci_checker #(
    parameter  int N_VOLT = 6,
    parameter  int N_FAN  = 2,
    parameter  int DW     = 8,
    localparam int NSRC   = N_VOLT + N_FAN + 2,
    localparam int CHW    = $clog2(NSRC + 1),
    localparam int SW     = lci_pkg::STAT_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 meas_valid,
    input logic [CHW-1:0]       meas_chan,
    input logic [DW-1:0]        meas_value,
    input logic [N_VOLT*DW-1:0] volt_hi,
    input logic [N_VOLT*DW-1:0] volt_lo,
    input logic [N_FAN*DW-1:0]  fan_lim,
    input logic                 chassis_in,
    input logic                 int_enable,
    input logic                 int_clear,
    input logic                 rd_stat0,
    input logic                 rd_stat1,
    input logic [7:0]           stat0,
    input logic [7:0]           stat1,
    input logic                 int_n
);
    localparam int TBIT = N_VOLT;
    localparam int CBIT = N_VOLT + N_FAN + 1;
    localparam logic [SW-1:0] TMASK = SW'(1) << TBIT;

    logic [SW-1:0] all;
    logic          live;
    assign all  = {stat1, stat0};
    assign live = meas_valid && !int_clear;

    p_int_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_enable || int_clear) |-> int_n);

    p_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clear && !rd_stat0 && !rd_stat1 && !chassis_in) |=> $stable(all));

    p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat0 && !live && (CBIT >= 8 || !chassis_in)) |=> (stat0 == 8'h00));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stat0 && !rd_stat1) |=>
            ((all & $past(all) & ~TMASK) == ($past(all) & ~TMASK)));

    p_chassis_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chassis_in |=> all[CBIT]);

    p_volt_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (int'(meas_chan) < N_VOLT) &&
         (meas_value > volt_hi[meas_chan*DW +: DW])) |=> all[$past(meas_chan)]);

    p_fan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (int'(meas_chan) > N_VOLT) && (int'(meas_chan) < CBIT) &&
         (meas_value > fan_lim[(int'(meas_chan) - N_VOLT - 1)*DW +: DW]))
        |=> all[$past(meas_chan)]);

    logic unused_ok;
    assign unused_ok = ^volt_lo;

endmodule

bind limit_irq_ctrl lci_checker #(
    .N_VOLT (N_VOLT),
    .N_FAN  (N_FAN),
    .DW     (DW)
) i_lci_checker (.*);

// File: tb/test_limit_irq_ctrl.sv
module test_limit_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_valid = 1'b0;
    logic [3:0]  meas_chan = '0;
    logic [7:0]  meas_value = '0;
    logic [47:0] volt_hi = {6{8'd200}};
    logic [47:0] volt_lo = {6{8'd50}};
    logic [15:0] fan_lim = {2{8'd150}};
    logic [7:0]  temp_hi = 8'd50;
    logic [7:0]  temp_hyst = 8'd40;
    logic        mode_we = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic [15:0] irq_mask = '0;
    logic        chassis_in = 1'b0;
    logic        int_enable = 1'b0;
    logic        int_clear = 1'b0;
    logic        rd_stat0 = 1'b0;
    logic        rd_stat1 = 1'b0;
    logic [7:0]  stat0;
    logic [7:0]  stat1;
    logic        int_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    limit_irq_ctrl i_limit_irq_ctrl (
        .clk, .rst_n, .meas_valid, .meas_chan, .meas_value,
        .volt_hi, .volt_lo, .fan_lim, .temp_hi, .temp_hyst,
        .mode_we, .mode_wdata, .irq_mask, .chassis_in,
        .int_enable, .int_clear, .rd_stat0, .rd_stat1,
        .stat0, .stat1, .int_n
    );

    // {channel, value, expected {stat1,stat0}} in mode 00
    localparam logic [27:0] VEC [16] = '{
        {4'd0, 8'd201, 16'h0001},
        {4'd0, 8'd200, 16'h0000},
        {4'd1, 8'd49,  16'h0002},
        {4'd1, 8'd50,  16'h0000},
        {4'd5, 8'd255, 16'h0020},
        {4'd7, 8'd151, 16'h0080},
        {4'd8, 8'd150, 16'h0000},
        {4'd8, 8'd255, 16'h0100},
        {4'd6, 8'd50,  16'h0000},
        {4'd6, 8'd51,  16'h0040},
        {4'd6, 8'd45,  16'h0040},
        {4'd6, 8'd40,  16'h0040},
        {4'd6, 8'd39,  16'h0000},
        {4'd6, 8'h9C,  16'h0000},
        {4'd6, 8'd45,  16'h0000},
        {4'd9, 8'd255, 16'h0000}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic meas(input logic [3:0] ch, input logic [7:0] v);
        @(negedge clk);
        meas_valid = 1'b1; meas_chan = ch; meas_value = v;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic read_all();
        @(negedge clk);
        rd_stat0 = 1'b1; rd_stat1 = 1'b1;
        @(negedge clk);
        rd_stat0 = 1'b0; rd_stat1 = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk({stat1, stat0}, 16'h0000, "R3 reset status");
        chk({15'd0, int_n}, 16'h0001, "R5 reset int_n");
        rst_n = 1'b1;

        // R8/R10: reset mode is one-shot
        meas(4'd6, 8'd60);
        chk({stat1, stat0}, 16'h0040, "R10 first hot");
        read_all();
        meas(4'd6, 8'd60);
        chk({stat1, stat0}, 16'h0000, "R8 R10 no repeat while hot");
        meas(4'd6, 8'd45);
        meas(4'd6, 8'd30);
        chk({stat1, stat0}, 16'h0000, "R10 cooling quiet");
        meas(4'd6, 8'd55);
        chk({stat1, stat0}, 16'h0040, "R10 re-armed after hysteresis");
        read_all();
        meas(4'd6, 8'd30);
        read_all();

        // table walk in mode 00
        set_mode(2'b00);
        for (int i = 0; i < 16; i++) begin
            meas(VEC[i][27:24], VEC[i][23:16]);
            chk({stat1, stat0}, VEC[i][15:0],
                $sformatf("R1 R2 R9 R12 R13 vector %0d", i));
            read_all();
        end

        // R3: byte-wise read clear
        meas(4'd0, 8'd250);
        meas(4'd8, 8'd250);
        @(negedge clk);
        rd_stat1 = 1'b1;
        @(negedge clk);
        rd_stat1 = 1'b0;
        chk({stat1, stat0}, 16'h0001, "R3 byte1 read leaves byte0");
        @(negedge clk);
        rd_stat0 = 1'b1;
        #1;
        chk({8'h00, stat0}, 16'h0001, "R3 value visible in read cycle");
        @(negedge clk);
        rd_stat0 = 1'b0;
        chk({stat1, stat0}, 16'h0000, "R3 cleared after read");

        // R4/R5 interrupt gating
        meas(4'd0, 8'd250);
        int_enable = 1'b1;
        #1;
        chk({15'd0, int_n}, 16'h0000, "R5 int_n low");
        irq_mask = 16'h0001;
        #1;
        chk({15'd0, int_n}, 16'h0001, "R4 masked bit");
        irq_mask = 16'h0000;
        int_enable = 1'b0;
        #1;
        chk({15'd0, int_n}, 16'h0001, "R5 disabled");
        int_enable = 1'b1;

        // R6 clear input pauses
        int_clear = 1'b1;
        #1;
        chk({15'd0, int_n}, 16'h0001, "R6 int_n released");
        meas(4'd1, 8'd0);
        chk({stat1, stat0}, 16'h0001, "R6 status kept, measurement ignored");
        int_clear = 1'b0;
        #1;
        chk({15'd0, int_n}, 16'h0000, "R6 resumes");
        int_enable = 1'b0;
        read_all();

        // R7 chassis
        @(negedge clk);
        chassis_in = 1'b1;
        @(negedge clk);
        chk({stat1, stat0}, 16'h0200, "R7 chassis set");
        read_all();
        chk({stat1, stat0}, 16'h0200, "R7 held while high");
        chassis_in = 1'b0;
        read_all();
        chk({stat1, stat0}, 16'h0000, "R7 cleared after low");

        // R11 comparator mode
        set_mode(2'b10);
        meas(4'd6, 8'd60);
        chk({stat1, stat0}, 16'h0040, "R11 hot");
        meas(4'd6, 8'd45);
        chk({stat1, stat0}, 16'h0000, "R11 follows comparison");

        // R9 mode 11 behaves as repeat: still hot from 60
        set_mode(2'b11);
        meas(4'd6, 8'd45);
        chk({stat1, stat0}, 16'h0040, "R9 mode 11 repeats while above hysteresis");
        read_all();
        meas(4'd6, 8'd30);
        chk({stat1, stat0}, 16'h0000, "R9 mode 11 stops below hysteresis");

        wrap_up();
    end

endmodule